// File: doc/BRIEF.md
# Alternating-Buffer Boot Stream Transmitter

This block sends a boot image, one bit per clock, on a single card data line in answer to a boot request. It runs on the clock that the host drives. Two transmit buffers of equal size are sent in strict turn, starting with buffer 0. While one buffer is being shifted out, a local writer refills the other. A per-buffer free flag tells the writer which buffer it may reload. The writer fills a buffer with 32-bit words and then seals it with a byte length. That length may be shorter than the buffer for the final piece of the image.

Whenever no sealed data is waiting, the line is held high, so the host reads all-ones bytes. A start request is accepted only once both buffers have been sealed. An abort request cancels the stream at once. It returns the line to high, empties both buffers and clears every counter.

Top module: `boot_stream_tx`

## Requirements
- R1: After reset `dat0` is high, `buf_free` is 2'b11 and the stream is inactive.
- R2: While the stream is inactive, or while the buffer whose turn it is has not been sealed, `dat0` is high on every cycle.
- R3: `start` is accepted only when the stream is inactive and both buffers are sealed; otherwise it has no effect. An accepted start always begins with buffer 0 at byte 0.
- R4: Byte 4k+j of a buffer is taken from `wr_data[31-8j:24-8j]` of the word written at `wr_addr` = k. Each byte is sent most significant bit first, one bit per clock. `dat0` changes on the falling edge. The first bit appears on the falling edge after the first rising edge that follows the accepted start (or seal).
- R5: When the last bit of a buffer has been sent, that buffer's `buf_free` bit rises. If the other buffer is sealed, its byte 0 follows on the next clock with no gap.
- R6: If the next buffer is not sealed when the current one finishes, `dat0` stays high until it is sealed. Sending then resumes at byte 0 of that buffer, and data already sent is never repeated.
- R7: A seal sets the buffer length to `seal_len`, which must lie in 1..BUF_BYTES; any other value is ignored. Only that many bytes are sent, and the line then returns high.
- R8: Word writes and seals aimed at a buffer whose `buf_free` bit is 0 are ignored. Its content and length are kept.
- R9: On the cycle after `abort`, `dat0` is high, `buf_free` is 2'b11, the stream is inactive and all counters are zero. A new transfer then needs a full fill and a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-driven card clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Boot request pulse |
| abort | input | 1 | Cancel pulse (idle command seen) |
| wr_en | input | 1 | Word write strobe |
| wr_buf | input | 1 | Buffer chosen for the write |
| wr_addr | input | $clog2(BUF_BYTES/4) | Word index within the buffer |
| wr_data | input | 32 | Word data, first byte in the top lane |
| seal | input | 1 | Mark a buffer as ready to send |
| seal_buf | input | 1 | Buffer chosen for the seal |
| seal_len | input | $clog2(BUF_BYTES+1) | Number of valid bytes in the sealed buffer |
| buf_free | output | 2 | Per-buffer flag: 1 means empty and writable |
| dat0 | output | 1 | Serial data line, idles high |

## Verification
Some rules are checked by assertions on every cycle. The line is high after any cycle with nothing to send and after an abort. An abort empties both buffers. A start takes effect only with both buffers sealed. Buffers swap at each drain. Sealed lengths stay in range, and a sealed buffer stays untouched until it drains. The directed scenarios alone can show the rest. These are the exact bit order and byte lanes on the line, and seamless handover with a refill made during transmission. They also cover the stall and resume at byte 0, a short final piece followed by idle, and the refusal of writes to sealed buffers with the original data still going out.

// File: rtl/bstx_pkg.sv
package bstx_pkg;
   localparam int WORD_BYTES = 4;
   localparam int WORD_BITS  = 8 * WORD_BYTES;

   typedef logic [WORD_BITS-1:0] word_t;
   typedef logic [7:0]           byte_t;

   // lane 0 is the byte sent first and sits in the top bits of the word
   function automatic byte_t lane_byte(word_t w, logic [1:0] lane);
      return w[(WORD_BITS - 1) - 8 * int'(lane) -: 8];
   endfunction
endpackage

// File: rtl/bstx_bank.sv
module bstx_bank
   import bstx_pkg::*;
#(
   parameter  int BUF_BYTES = 128,
   localparam int WORDS     = BUF_BYTES / WORD_BYTES,
   localparam int AW        = $clog2(WORDS),
   localparam int IW        = $clog2(BUF_BYTES)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          wr_buf,
   input  logic [AW-1:0] wr_addr,
   input  word_t         wr_data,
   input  logic [1:0]    wr_allow,
   input  logic          rd_buf,
   input  logic [IW-1:0] rd_idx,
   output byte_t         rd_byte
);
   word_t [1:0] rd_word;

   for (genvar b = 0; b < 2; b++) begin : g_half
      word_t mem [WORDS];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_buf == 1'(b)) && wr_allow[b])
            mem[wr_addr] <= wr_data;
      end

      assign rd_word[b] = mem[rd_idx[IW-1:2]];
   end

   assign rd_byte = lane_byte(rd_word[rd_buf], rd_idx[1:0]);
endmodule

// File: rtl/bstx_seq.sv
module bstx_seq #(
   parameter  int BUF_BYTES = 128,
   localparam int IW        = $clog2(BUF_BYTES),
   localparam int LW        = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic          seal,
   input  logic          seal_buf,
   input  logic [LW-1:0] seal_len,
   output logic [1:0]    ready,
   output logic          emit,
   output logic          cur,
   output logic [IW-1:0] byte_idx,
   output logic [2:0]    bit_idx
);
   logic [LW-1:0] len_q [2];
   logic          active;
   logic          last;
   logic          seal_ok;
   logic          go;

   assign emit    = active && ready[cur];
   assign last    = emit && (bit_idx == 3'd7) &&
                    (byte_idx == IW'(len_q[cur] - LW'(1)));
   assign seal_ok = seal && !ready[seal_buf] && (seal_len != '0) &&
                    (seal_len <= LW'(BUF_BYTES));
   assign go      = start && !active && (&ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready    <= '0;
         active   <= 1'b0;
         cur      <= 1'b0;
         byte_idx <= '0;
         bit_idx  <= '0;
         for (int i = 0; i < 2; i++) len_q[i] <= '0;
      end else if (abort) begin
         ready    <= '0;
         active   <= 1'b0;
         cur      <= 1'b0;
         byte_idx <= '0;
         bit_idx  <= '0;
      end else begin
         if (go) begin
            active   <= 1'b1;
            cur      <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
         end
         if (emit) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
               if (last) begin
                  byte_idx <= '0;
                  cur      <= ~cur;
               end else begin
                  byte_idx <= byte_idx + IW'(1);
               end
            end
         end
         for (int i = 0; i < 2; i++) begin
            if (last && (cur == 1'(i))) begin
               ready[i] <= 1'b0;
            end else if (seal_ok && (seal_buf == 1'(i))) begin
               ready[i] <= 1'b1;
               len_q[i] <= seal_len;
            end
         end
      end
   end

   AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> ($past(ready) == 2'b11)); // R3
   AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ((ready == 2'b00) && !active && (byte_idx == '0) && (bit_idx == '0))); // R9
   AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !abort) |=> (cur != $past(cur))); // R5

   for (genvar g = 0; g < 2; g++) begin : g_chk
      AST_SEAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ready[g]) |-> ((len_q[g] != '0) && (len_q[g] <= LW'(BUF_BYTES)))); // R7
      AST_SEALED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (ready[g] && !abort && !(last && (cur == 1'(g)))) |=>
            (ready[g] && $stable(len_q[g]))); // R8
   end
endmodule

// File: rtl/bstx_shift.sv
module bstx_shift
   import bstx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       emit,
   input  byte_t      rd_byte,
   input  logic [2:0] bit_idx,
   output logic       dat0
);
   logic sh_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_bit <= 1'b1;
      else if (abort || !emit)
         sh_bit <= 1'b1;
      else
         sh_bit <= rd_byte[3'd7 - bit_idx];
   end

   // the line is retimed to the falling edge for the host to sample on the rise
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         dat0 <= 1'b1;
      else
         dat0 <= sh_bit;
   end
endmodule

// File: rtl/boot_stream_tx.sv
module boot_stream_tx
   import bstx_pkg::*;
#(
   parameter  int BUF_BYTES = 128,
   localparam int AW        = $clog2(BUF_BYTES / WORD_BYTES),
   localparam int IW        = $clog2(BUF_BYTES),
   localparam int LW        = $clog2(BUF_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 abort,
   input  logic                 wr_en,
   input  logic                 wr_buf,
   input  logic [AW-1:0]        wr_addr,
   input  logic [WORD_BITS-1:0] wr_data,
   input  logic                 seal,
   input  logic                 seal_buf,
   input  logic [LW-1:0]        seal_len,
   output logic [1:0]           buf_free,
   output logic                 dat0
);
   if (BUF_BYTES < 2 * WORD_BYTES) begin : g_err_small
      $error("BUF_BYTES must hold at least two words");
   end
   if ((BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_err_pow2
      $error("BUF_BYTES must be a power of two");
   end

   logic [1:0]    ready;
   logic          emit;
   logic          cur;
   logic [IW-1:0] byte_idx;
   logic [2:0]    bit_idx;
   byte_t         rd_byte;

   bstx_seq #(.BUF_BYTES(BUF_BYTES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .abort    (abort),
      .seal     (seal),
      .seal_buf (seal_buf),
      .seal_len (seal_len),
      .ready    (ready),
      .emit     (emit),
      .cur      (cur),
      .byte_idx (byte_idx),
      .bit_idx  (bit_idx)
   );

   bstx_bank #(.BUF_BYTES(BUF_BYTES)) u_bank (
      .clk      (clk),
      .wr_en    (wr_en),
      .wr_buf   (wr_buf),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_allow (~ready),
      .rd_buf   (cur),
      .rd_idx   (byte_idx),
      .rd_byte  (rd_byte)
   );

   bstx_shift u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (abort),
      .emit    (emit),
      .rd_byte (rd_byte),
      .bit_idx (bit_idx),
      .dat0    (dat0)
   );

   assign buf_free = ~ready;

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !emit |=> dat0); // R2
   AST_ABORT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (dat0 && (buf_free == 2'b11))); // R9
endmodule

// File: tb/boot_stream_tx_bench.sv
`timescale 1ns/1ps
module boot_stream_tx_bench;
   localparam int BB = 16;
   localparam int AW = $clog2(BB / 4);
   localparam int LW = $clog2(BB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, abort = 1'b0;
   logic          wr_en = 1'b0, wr_buf = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          seal = 1'b0, seal_buf = 1'b0;
   logic [LW-1:0] seal_len = '0;
   logic [1:0]    buf_free;
   logic          dat0;

   int errs = 0, checks = 0;
   logic [7:0] rx [64];

   always #2 clk = ~clk;

   boot_stream_tx #(.BUF_BYTES(BB)) u_boot_stream_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
      .seal(seal), .seal_buf(seal_buf), .seal_len(seal_len),
      .buf_free(buf_free), .dat0(dat0)
   );

   function automatic logic [7:0] pat(int seed, int i);
      return 8'((seed * 71 + i * 37) ^ (i * 8));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_word(input logic b, input int w, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_buf = b; wr_addr = AW'(w); wr_data = d;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic do_seal(input logic b, input int n);
      @(negedge clk);
      seal = 1'b1; seal_buf = b; seal_len = LW'(n);
      @(posedge clk); #1 seal = 1'b0;
   endtask

   task automatic fill(input logic b, input int n, input int seed);
      for (int w = 0; w < (n + 3) / 4; w++) begin
         logic [31:0] d;
         for (int j = 0; j < 4; j++)
            d[31 - 8 * j -: 8] = (w * 4 + j < n) ? pat(seed, w * 4 + j) : 8'hA5;
         put_word(b, w, d);
      end
      do_seal(b, n);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   task automatic pulse_abort();
      @(negedge clk); abort = 1'b1;
      @(posedge clk); #1 abort = 1'b0;
   endtask

   task automatic collect(input int n, input int at);
      for (int i = 0; i < n; i++) begin
         logic [7:0] v;
         for (int b = 0; b < 8; b++) begin
            @(posedge clk); #3;
            v = {v[6:0], dat0};
         end
         rx[at + i] = v;
      end
   endtask

   task automatic cmp(input int at, input int n, input int seed, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++)
         if (rx[at + i] !== pat(seed, i)) begin
            bad++;
            chk(1'b0, req, $sformatf("byte %0d", i), rx[at + i], pat(seed, i));
         end
      if (bad == 0) chk(1'b1, req, "bytes", 0, 0);
   endtask

   task automatic hold_high(input int n, input string req);
      int lows = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #3;
         if (dat0 !== 1'b1) lows++;
      end
      chk(lows == 0, req, "cycles with line low", lows, 0);
   endtask

   task automatic t_reset();
      chk(dat0 === 1'b1, "R1", "dat0 after reset", dat0, 1);
      chk(buf_free === 2'b11, "R1", "buf_free after reset", buf_free, 3);
      hold_high(8, "R1");
   endtask

   task automatic t_start_gate();
      fill(1'b0, BB, 1);
      chk(buf_free === 2'b10, "R3", "free after one fill", buf_free, 2);
      pulse_start();
      hold_high(24, "R3");
      chk(buf_free === 2'b10, "R3", "start refused with one buffer", buf_free, 2);
   endtask

   // R4 R5: both halves, then a refill of buffer 0 while buffer 1 is on the line
   task automatic t_stream();
      fill(1'b1, BB, 2);
      pulse_start();
      fork
         collect(3 * BB, 0);
         begin
            wait (buf_free[0] === 1'b1);
            chk(buf_free[1] === 1'b0, "R5", "other buffer busy at handover", buf_free[1], 0);
            fill(1'b0, BB, 3);
         end
      join
      cmp(0, BB, 1, "R4");
      cmp(BB, BB, 2, "R5");
      cmp(2 * BB, BB, 3, "R5");
   endtask

   task automatic t_stall_short();
      hold_high(24, "R6");
      chk(buf_free === 2'b11, "R6", "both free while stalled", buf_free, 3);
      fill(1'b1, 5, 4);
      collect(5, 0);
      cmp(0, 5, 4, "R7");
      hold_high(20, "R7");
   endtask

   task automatic t_abort();
      fill(1'b0, BB, 5);
      collect(1, 0);
      cmp(0, 1, 5, "R6");
      for (int i = 0; i < 4; i++) @(posedge clk);
      pulse_abort();
      chk(buf_free === 2'b11, "R9", "free after abort", buf_free, 3);
      hold_high(30, "R9");
      pulse_start();
      hold_high(20, "R9");
   endtask

   task automatic t_protect();
      fill(1'b0, BB, 6);
      put_word(1'b0, 0, 32'h0000_0000);
      do_seal(1'b0, 3);
      do_seal(1'b1, 0);
      chk(buf_free === 2'b10, "R7", "zero-length seal ignored", buf_free, 2);
      do_seal(1'b1, BB + 1);
      chk(buf_free === 2'b10, "R7", "oversize seal ignored", buf_free, 2);
      fill(1'b1, BB, 7);
      pulse_start();
      collect(2 * BB, 0);
      cmp(0, BB, 6, "R8");
      cmp(BB, BB, 7, "R3");
      hold_high(12, "R2");
   endtask

   initial begin
      #(4 * 200000);
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_start_gate();
      t_stream();
      t_stall_short();
      t_abort();
      t_protect();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule